// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked user port and an external asynchronous static RAM. The RAM is organised as 32K words of 8 bits and has active-low chip enable, write enable and output enable. The user side issues one access at a time with a valid/ready handshake. Each request carries a read/write flag, an address and write data. Read results come back on a data register that is qualified by a one-clock strobe. On the memory side the controller drives the address and the three strobes. It splits the bidirectional data pins into a data-out bus, a data-in bus and a drive-enable, so the pad tristate stays outside the block.

The memory has no clock, so every timing limit is met by holding a strobe state for a whole number of clock cycles. Each cycle count comes from a nanosecond parameter and a clock-period parameter. The controller rounds each interval up, with a floor of one cycle. A write is a WE-controlled pulse: chip enable and write enable fall together and rise together, and output enable stays high throughout. The controller starts driving the data pins only once the memory has had time to release them after a read.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are all 1, `sram_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken only at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the edge after acceptance until the access is complete. A request raised and withdrawn while the controller is busy has no effect on memory.
- R3: A read holds `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 with a stable address for exactly N_RD cycles, starting the cycle after acceptance. N_RD = max(ceil(tRC), ceil(tAA), ceil(tDOE)), where each ceil is ns / period rounded up with a minimum of 1. This gives 7 at the defaults (70, 70, 35 ns, 10 ns period).
- R4: `sram_dq_in` is captured on the last cycle of the read window. `rsp_valid` is 1 for exactly one clock, N_RD+1 cycles after the accepting edge, and `rsp_rdata` then equals the memory word at the requested address.
- R5: A write pulls `sram_ce_n` and `sram_we_n` low together and holds them low for exactly N_WE = max(ceil(tPWE), ceil(tAW), ceil(tSD)) cycles, which is 6 at the defaults (50, 60, 30 ns). During the pulse `sram_oe_n` is 1 and the address and data-out are stable. Both strobes then rise on the same edge.
- R6: A write occupies N_WC = max(ceil(tWC), N_WE+1) cycles from the first strobe cycle to the return to idle. This is 7 at the defaults (70 ns).
- R7: `sram_dq_oe` rises in the same cycle that `sram_we_n` falls and falls exactly one cycle after `sram_we_n` rises. It is never 1 while `sram_oe_n` is 0.
- R8: `sram_dq_oe` does not rise until `sram_oe_n` has been 1 for at least N_HZ = ceil(tHZOE) cycles, which is 3 at the defaults (25 ns). A write taken on the first idle cycle after a read therefore starts its strobe N_HZ-1 cycles later than a write taken with the bus already free.
- R9: `rsp_valid` pulses once per read and never during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (15) | Word address |
| req_wdata | input | DATA_W (8) | Write data |
| rsp_rdata | output | DATA_W (8) | Last captured read word |
| rsp_valid | output | 1 | One-clock strobe marking new read data |
| sram_addr | output | ADDR_W (15) | Memory address pins |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_dq_out | output | DATA_W (8) | Value to place on the data pins |
| sram_dq_in | input | DATA_W (8) | Value sensed on the data pins |
| sram_dq_oe | output | 1 | Drive enable for the data pins |

## Verification
Each result is counted from the edge that accepts a request. For a read, `rsp_valid`, the data word and `req_ready` are all due N_RD+1 cycles later. A write returns to idle N_WC+1 cycles later, plus N_HZ-1 cycles when it directly follows a read. The bench drives and samples on the falling clock edge and counts falling edges from the acceptance, so every result is compared at the cycle the requirement fixes. A strobe monitor measures each read window, write pulse, drive-enable edge and bus-release gap in whole cycles. Its memory model returns a poison value until N_RD-1 full read cycles have elapsed, which catches any early capture.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WPULSE,
        ST_WREC
    } ctrl_state_e;

    // Whole clock cycles that cover an interval, never fewer than one.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_bus_release.sv
`timescale 1ns/1ps
// Counts the cycles the memory needs to float its outputs after a read.
module sram_bus_release #(
    parameter int HOLD_CYC = 3,
    parameter int CNT_W    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic free_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = CNT_W'(HOLD_CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // The edge that takes the count from 1 to 0 completes the interval,
    // so a drive starting at that edge is already safe.
    assign free_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
// Holds the last word sensed from the memory and flags it for one clock.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              valid_o
);
    logic [DATA_W-1:0] data_d, data_q;
    logic              vld_d, vld_q;

    always_comb begin
        data_d = cap_i ? din_i : data_q;
        vld_d  = cap_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            vld_q  <= vld_d;
        end
    end

    assign rdata_o = data_q;
    assign valid_o = vld_q;
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RC_NS       = 70,
    parameter int T_AA_NS       = 70,
    parameter int T_DOE_NS      = 35,
    parameter int T_WC_NS       = 70,
    parameter int T_PWE_NS      = 50,
    parameter int T_AW_NS       = 60,
    parameter int T_SD_NS       = 30,
    parameter int T_HZOE_NS     = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe
);
    // Strobe intervals in whole clock cycles.
    localparam int N_RD   = imax(imax(ns_to_cycles(T_RC_NS, CLK_PERIOD_NS),
                                      ns_to_cycles(T_AA_NS, CLK_PERIOD_NS)),
                                 ns_to_cycles(T_DOE_NS, CLK_PERIOD_NS));
    localparam int N_WE   = imax(imax(ns_to_cycles(T_PWE_NS, CLK_PERIOD_NS),
                                      ns_to_cycles(T_AW_NS, CLK_PERIOD_NS)),
                                 ns_to_cycles(T_SD_NS, CLK_PERIOD_NS));
    localparam int N_WC   = imax(ns_to_cycles(T_WC_NS, CLK_PERIOD_NS), N_WE + 1);
    localparam int N_WREC = N_WC - N_WE;
    localparam int N_HZ   = ns_to_cycles(T_HZOE_NS, CLK_PERIOD_NS);
    localparam int CNT_MAX = imax(imax(N_RD, N_WE), N_WREC);
    localparam int CNT_W  = $clog2(CNT_MAX + 1);
    localparam int HZ_W   = $clog2(N_HZ + 1);

    typedef struct packed {
        ctrl_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        state: ST_IDLE, cnt: '0, addr: '0, wdata: '0,
        ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0
    };

    ctrl_t cur_q, nxt_d;
    logic  rd_cap;
    logic  rel_start;
    logic  bus_free;

    sram_bus_release #(
        .HOLD_CYC (N_HZ),
        .CNT_W    (HZ_W)
    ) u_release (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rel_start),
        .free_o  (bus_free)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (rd_cap),
        .din_i   (sram_dq_in),
        .rdata_o (rsp_rdata),
        .valid_o (rsp_valid)
    );

    always_comb begin
        nxt_d     = cur_q;
        rd_cap    = 1'b0;
        rel_start = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.addr  = req_addr;
                    nxt_d.wdata = req_wdata;
                    if (!req_write) begin
                        nxt_d.state = ST_READ;
                        nxt_d.ce_n  = 1'b0;
                        nxt_d.oe_n  = 1'b0;
                        nxt_d.cnt   = CNT_W'(N_RD - 1);
                    end else if (bus_free) begin
                        nxt_d.state = ST_WPULSE;
                        nxt_d.ce_n  = 1'b0;
                        nxt_d.we_n  = 1'b0;
                        nxt_d.dq_oe = 1'b1;
                        nxt_d.cnt   = CNT_W'(N_WE - 1);
                    end else begin
                        nxt_d.state = ST_TURN;
                    end
                end
            end
            ST_READ: begin
                if (cur_q.cnt == '0) begin
                    rd_cap      = 1'b1;
                    rel_start   = 1'b1;
                    nxt_d.ce_n  = 1'b1;
                    nxt_d.oe_n  = 1'b1;
                    nxt_d.state = ST_IDLE;
                end else begin
                    nxt_d.cnt = cur_q.cnt - CNT_W'(1);
                end
            end
            ST_TURN: begin
                // Strobes stay high until the memory has floated its outputs.
                if (bus_free) begin
                    nxt_d.state = ST_WPULSE;
                    nxt_d.ce_n  = 1'b0;
                    nxt_d.we_n  = 1'b0;
                    nxt_d.dq_oe = 1'b1;
                    nxt_d.cnt   = CNT_W'(N_WE - 1);
                end
            end
            ST_WPULSE: begin
                if (cur_q.cnt == '0) begin
                    // Both strobes end the write on one edge; data stays driven.
                    nxt_d.ce_n  = 1'b1;
                    nxt_d.we_n  = 1'b1;
                    nxt_d.cnt   = CNT_W'(N_WREC - 1);
                    nxt_d.state = ST_WREC;
                end else begin
                    nxt_d.cnt = cur_q.cnt - CNT_W'(1);
                end
            end
            ST_WREC: begin
                nxt_d.dq_oe = 1'b0;
                if (cur_q.cnt == '0)
                    nxt_d.state = ST_IDLE;
                else
                    nxt_d.cnt = cur_q.cnt - CNT_W'(1);
            end
            default: nxt_d = CTRL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= CTRL_RST;
        else        cur_q <= nxt_d;
    end

    assign req_ready   = (cur_q.state == ST_IDLE);
    assign sram_addr   = cur_q.addr;
    assign sram_ce_n   = cur_q.ce_n;
    assign sram_we_n   = cur_q.we_n;
    assign sram_oe_n   = cur_q.oe_n;
    assign sram_dq_out = cur_q.wdata;
    assign sram_dq_oe  = cur_q.dq_oe;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int N_WE   = 6,
    parameter int N_HZ   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe
);
    logic [7:0] we_low_cnt;
    logic [7:0] oe_high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt  <= 8'd0;
            oe_high_cnt <= 8'hFF;
        end else begin
            if (!sram_ce_n && !sram_we_n)
                we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 8'd1;
            else
                we_low_cnt <= 8'd0;
            if (sram_oe_n)
                oe_high_cnt <= (oe_high_cnt == 8'hFF) ? oe_high_cnt : oe_high_cnt + 8'd1;
            else
                oe_high_cnt <= 8'd0;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe)); // R1

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr)); // R3

    AST_RVALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R4

    AST_NO_READ_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n); // R5

    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt == 8'(N_WE))); // R5

    AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_dq_oe); // R7

    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (oe_high_cnt >= 8'(N_HZ))); // R8
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .N_WE   (N_WE),
    .N_HZ   (N_HZ)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;
    localparam int AW  = 8;
    localparam int DW  = 8;
    localparam int PER = 10;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction

    // Expected cycle counts, from the requirement formulas.
    localparam int E_RD = 7;   // max(ceil 70, ceil 70, ceil 35) / 10
    localparam int E_WE = 6;   // max(ceil 50, ceil 60, ceil 30) / 10
    localparam int E_WC = 7;   // max(ceil 70 / 10, E_WE + 1)
    localparam int E_HZ = 3;   // ceil 25 / 10

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_valid;
    logic [AW-1:0] sram_addr;
    logic          sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out, sram_dq_in;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W        (AW),
        .DATA_W        (DW),
        .CLK_PERIOD_NS (PER)
    ) u_sram_async_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_rdata   (rsp_rdata),
        .rsp_valid   (rsp_valid),
        .sram_addr   (sram_addr),
        .sram_ce_n   (sram_ce_n),
        .sram_we_n   (sram_we_n),
        .sram_oe_n   (sram_oe_n),
        .sram_dq_out (sram_dq_out),
        .sram_dq_in  (sram_dq_in),
        .sram_dq_oe  (sram_dq_oe)
    );

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [DW-1:0] mem [256];
    int rd_run;

    always @(posedge clk) begin
        if (!rst_n) rd_run <= 0;
        else if (!sram_ce_n && !sram_oe_n && sram_we_n) rd_run <= rd_run + 1;
        else rd_run <= 0;
    end

    // Poison value until the access time has elapsed.
    assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n && rd_run >= E_RD - 1)
                        ? mem[sram_addr] : 8'hEE;

    // ---------------- strobe monitor ----------------
    bit            p_wr, p_rd, p_dq_oe;
    int            we_run, rd_cnt, since_we, since_oe;
    bit            wr_ok, rd_ok;
    logic [AW-1:0] w_addr0, r_addr0;
    logic [DW-1:0] w_data0;

    always @(negedge clk) begin
        bit wr_act, rd_act;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = ~8'(i);
            p_wr = 0; p_rd = 0; p_dq_oe = 0;
            we_run = 0; rd_cnt = 0; since_we = 1000; since_oe = 1000;
            wr_ok = 1; rd_ok = 1;
        end else begin
            wr_act = !sram_ce_n && !sram_we_n;
            rd_act = !sram_ce_n && !sram_oe_n && sram_we_n;
            if (wr_act) begin
                if (!p_wr) begin w_addr0 = sram_addr; w_data0 = sram_dq_out; wr_ok = 1; end
                if (sram_addr != w_addr0 || sram_dq_out != w_data0 || !sram_oe_n || !sram_dq_oe)
                    wr_ok = 0;
                we_run++;
            end
            if (p_wr && !wr_act) begin
                chk(we_run == E_WE, "R5 write pulse width", we_run, E_WE);
                chk(wr_ok && sram_ce_n && sram_we_n, "R5 pulse stable, OE high, strobes rise together",
                    int'(wr_ok), 1);
                mem[w_addr0] = w_data0;
                we_run = 0;
                since_we = 1;
            end else if (since_we < 1000) since_we++;

            if (rd_act) begin
                if (!p_rd) begin r_addr0 = sram_addr; rd_ok = 1; end
                if (sram_addr != r_addr0 || sram_dq_oe) rd_ok = 0;
                rd_cnt++;
            end
            if (p_rd && !rd_act) begin
                chk(rd_cnt == E_RD, "R3 read window width", rd_cnt, E_RD);
                chk(rd_ok, "R3 read address held, no drive", int'(rd_ok), 1);
                rd_cnt = 0;
            end
            if (sram_oe_n) begin
                if (since_oe < 1000) since_oe++;
            end else since_oe = 0;

            if (sram_dq_oe && !p_dq_oe) begin
                chk(since_oe - 1 >= E_HZ, "R8 bus release before drive", since_oe - 1, E_HZ);
                chk(!sram_we_n, "R7 drive starts with WE low", int'(sram_we_n), 0);
            end
            if (!sram_dq_oe && p_dq_oe)
                chk(since_we == 2, "R7 drive ends one cycle after WE rises", since_we - 1, 1);
            p_wr = wr_act; p_rd = rd_act; p_dq_oe = sram_dq_oe;
        end
    end

    // ---------------- stimulus ----------------
    logic [DW-1:0] exp_mem [256];
    bit prev_rd = 0;

    task automatic do_read(input int a);
        int cyc, rvn, rvc;
        logic [DW-1:0] got;
        chk(req_ready, "R2 ready before read", int'(req_ready), 1);
        req_valid = 1; req_write = 0; req_addr = AW'(a);
        cyc = 0; rvn = 0; rvc = 0; got = '0;
        do begin
            @(negedge clk); cyc++;
            if (cyc == 1) req_valid = 0;
            if (rsp_valid) begin rvn++; rvc = cyc; got = rsp_rdata; end
        end while (!req_ready && cyc < 60);
        chk(cyc == E_RD + 1, "R2 read busy length", cyc, E_RD + 1);
        chk(rvn == 1 && rvc == E_RD + 1, "R4 rvalid single pulse at window end", rvc, E_RD + 1);
        chk(got == exp_mem[a], "R4 read data", int'(got), int'(exp_mem[a]));
        prev_rd = 1;
    endtask

    task automatic do_write(input int a, input int d, input bit noise, input int na, input int nd);
        int cyc, rvn, exp_cyc;
        bit early_rdy;
        exp_cyc = E_WC + 1 + (prev_rd ? E_HZ - 1 : 0);
        chk(req_ready, "R2 ready before write", int'(req_ready), 1);
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = DW'(d);
        cyc = 0; rvn = 0; early_rdy = 0;
        do begin
            @(negedge clk); cyc++;
            if (cyc == 1) req_valid = 0;
            if (noise && cyc == 2) begin
                req_valid = 1; req_write = 1; req_addr = AW'(na); req_wdata = DW'(nd);
            end
            if (noise && cyc == 5) req_valid = 0;
            if (rsp_valid) rvn++;
            if (req_ready && cyc < exp_cyc) early_rdy = 1;
        end while (!req_ready && cyc < 60);
        chk(cyc == exp_cyc, "R6 write occupancy (R8 turnaround included)", cyc, exp_cyc);
        chk(!early_rdy, "R2 ready low while busy", int'(early_rdy), 0);
        chk(rvn == 0, "R9 no rvalid during write", rvn, 0);
        exp_mem[a] = DW'(d);
        prev_rd = 0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = ~8'(i);
        repeat (3) @(negedge clk);
        chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes high in reset", int'(sram_ce_n), 1);
        chk(!sram_dq_oe && !rsp_valid, "R1 no drive, no rvalid in reset", int'(sram_dq_oe), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(req_ready && sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe,
            "R1 idle after reset", int'(req_ready), 1);

        // Reads of untouched words (R3, R4).
        for (int a = 0; a < 16; a++) do_read(a);
        // Full write sweep (R5, R6, R7).
        for (int a = 0; a < 256; a++) do_write(a, (a * 37 + 5) & 255, 0, 0, 0);
        // Full read sweep (R4, R9).
        for (int a = 0; a < 256; a++) do_read(a);
        // Read / write / read turnaround pattern (R8).
        for (int a = 0; a < 32; a++) begin
            do_read(a);
            do_write(a, a ^ 8'h5A, 0, 0, 0);
            do_read(a);
        end
        // Request raised while busy must be ignored (R2).
        do_write(8'h40, 8'h77, 1, 8'h80, 8'h99);
        do_read(8'h80);
        do_read(8'h40);
        @(negedge clk);
        chk(req_ready && sram_ce_n && sram_oe_n && !rsp_valid, "R1 idle at end", int'(req_ready), 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule